// File: doc/BRIEF.md
# Halt and Wakeup Controller

This block governs the low-power stop state of a small fully static processor core. While the core runs, a one-cycle strobe from the core's port register write path requests a stop. The controller then drops the core clock enable, and the whole core freezes in place. Three events end the stop:
- an active-low reset, which restarts the core at address zero;
- a multi-input wakeup request;
- a rising edge on the restart pin.

The last two resume the core at the instruction after the one that caused the stop.

When the two-pin crystal oscillator option is selected, the oscillator must settle before the core may run again. The controller reuses the watchdog prescaler and counter pair as a start-up timer. Both are loaded with all ones, and the prescaler is stepped once per instruction cycle. An instruction cycle is a fixed number of oscillator clocks. The core clock comes back after one full prescaler wrap. With the RC or external clock options, and for any reset exit, there is no delay. In those option cases the pair is still reloaded. The restart pin doubles as a synchronized general-purpose input level for the core.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `core_clk_en` and `restart_zero` are 0. On the first clock after release, `core_clk_en` is 1 and `restart_zero` is 1 for exactly one cycle. The prescaler and counter read 0 after reset.
- R2: A `halt_set` strobe while `core_clk_en` is 1 drives `core_clk_en` to 0 on the next clock, and it stays 0 until an exit event.
- R3: `halt_set` while stopped has no effect; `core_clk_en` stays 0.
- R4: With clock option RC or external, a rising edge on `restart_pin` while stopped sets `core_clk_en` and a one-cycle `resume_next` on the third clock edge after the pin rises. This is two synchronizer stages plus edge detection.
- R5: With the crystal option (`clk_opt` = 2'b00), a rising edge on `restart_pin` while stopped is ignored.
- R6: With clock option RC or external, `wake_req` while stopped sets `core_clk_en` and a one-cycle `resume_next` on the next clock, with no delay. `wake_req` while running has no effect.
- R7: With the crystal option, `wake_req` while stopped re-enables the core exactly 256 × TC_DIV oscillator clocks after the clock that accepted the request, and `resume_next` pulses with it.
- R8: An exit through `wake_req` or `restart_pin` loads the prescaler (`wdt_pre`) and counter (`wdt_cnt`) with all ones. After a crystal start-up delay the prescaler has wrapped back to all ones and the counter reads all ones minus one. After an RC or external exit both still read all ones.
- R9: Reset while stopped or during the start-up delay ends it at once: `core_clk_en` is 1 on the first clock after release and `restart_zero` pulses, not `resume_next`.
- R10: `wake_req` and restart-pin edges during the start-up delay neither shorten nor restart it.
- R11: `g7_level` equals the level of `restart_pin` delayed by two clock edges.
- R12: Clock option encoding: 2'b00 is crystal, 2'b01 is RC, and 2'b10 and 2'b11 are external clock. All non-crystal codes behave identically.
- R13: The instruction-cycle divider restarts on every stop entry, so each crystal start-up lasts the same number of clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| halt_set | input | 1 | One-cycle strobe: core writes the stop bit |
| restart_pin | input | 1 | Asynchronous restart pin / general-purpose input |
| wake_req | input | 1 | Multi-input wakeup request (synchronous) |
| clk_opt | input | 2 | Clock option: 00 crystal, 01 RC, 1x external |
| core_clk_en | output | 1 | Core clock enable |
| resume_next | output | 1 | One-cycle pulse: continue after the stop instruction |
| restart_zero | output | 1 | One-cycle pulse: restart at address zero |
| g7_level | output | 1 | Synchronized restart pin level |
| wdt_pre | output | 8 | Watchdog prescaler contents |
| wdt_cnt | output | 8 | Watchdog counter contents |

## Verification
The bench builds the controller with its default parameters: a divide-by-10 instruction cycle and 8-bit prescaler and counter. A full crystal start-up is then 2560 clocks, so it can be measured to the exact cycle several times, with stray wakeups injected mid-delay. All four clock option codes are swept against both non-reset exit sources. Reset exits are taken from the stopped state and from the middle of the start-up delay.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WARM = 2'd2
  } hwc_state_e;

  localparam logic [1:0] OPT_XTAL = 2'b00;
endpackage

// File: rtl/hwc_pin_sync.sv
module hwc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/hwc_tc_div.sv
module hwc_tc_div #(
  parameter int TC_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int DIV_W = (TC_DIV > 1) ? $clog2(TC_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TC_DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (en) begin
      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end

  assign tick = en && (div_q == LAST);
endmodule

// File: rtl/hwc_warm_timer.sv
module hwc_warm_timer #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             en,
  input  logic             tick,
  output logic [PRE_W-1:0] pre,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  logic pre_zero;
  assign pre_zero = (pre == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      cnt <= '0;
    end else if (load) begin
      pre <= '1;
      cnt <= '1;
    end else if (en && tick) begin
      pre <= pre - 1'b1;
      if (pre_zero) cnt <= cnt - 1'b1;
    end
  end

  assign done = en && tick && pre_zero;
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int TC_DIV   = 10,
  parameter int PRE_W    = 8,
  parameter int CNT_W    = 8,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_set,
  input  logic             restart_pin,
  input  logic             wake_req,
  input  logic [1:0]       clk_opt,
  output logic             core_clk_en,
  output logic             resume_next,
  output logic             restart_zero,
  output logic             g7_level,
  output logic [PRE_W-1:0] wdt_pre,
  output logic [CNT_W-1:0] wdt_cnt
);
  import hwc_pkg::*;

  logic       rst;
  hwc_state_e state_q;
  logic       rz_pend_q;
  logic       pin_rise;
  logic       is_xtal;
  logic       exit_hit;
  logic       enter_stop;
  logic       warm;
  logic       tc_tick;
  logic       warm_done;

  assign rst        = ~rst_n;
  assign is_xtal    = (clk_opt == OPT_XTAL);
  assign exit_hit   = (state_q == ST_STOP) && (wake_req || (pin_rise && !is_xtal));
  assign enter_stop = (state_q == ST_RUN) && core_clk_en && halt_set;
  assign warm       = (state_q == ST_WARM);

  hwc_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin   (restart_pin),
    .level (g7_level),
    .rise  (pin_rise)
  );

  hwc_tc_div #(.TC_DIV(TC_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (enter_stop),
    .en   (warm),
    .tick (tc_tick)
  );

  hwc_warm_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (exit_hit),
    .en   (warm),
    .tick (tc_tick),
    .pre  (wdt_pre),
    .cnt  (wdt_cnt),
    .done (warm_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RUN;
      core_clk_en  <= 1'b0;
      resume_next  <= 1'b0;
      restart_zero <= 1'b0;
      rz_pend_q    <= 1'b1;
    end else begin
      resume_next  <= 1'b0;
      restart_zero <= rz_pend_q;
      rz_pend_q    <= 1'b0;
      case (state_q)
        ST_RUN: begin
          if (enter_stop) begin
            state_q     <= ST_STOP;
            core_clk_en <= 1'b0;
          end else begin
            core_clk_en <= 1'b1;
          end
        end
        ST_STOP: begin
          if (exit_hit) begin
            if (is_xtal) begin
              state_q <= ST_WARM;
            end else begin
              state_q     <= ST_RUN;
              core_clk_en <= 1'b1;
              resume_next <= 1'b1;
            end
          end
        end
        ST_WARM: begin
          if (warm_done) begin
            state_q     <= ST_RUN;
            core_clk_en <= 1'b1;
            resume_next <= 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/halt_wake_ctrl_checker.sv
module halt_wake_ctrl_checker #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_set,
  input logic             core_clk_en,
  input logic             resume_next,
  input logic             restart_zero,
  input logic [PRE_W-1:0] wdt_pre,
  input logic [CNT_W-1:0] wdt_cnt
);
  // R1, R9: the two restart indications never coincide
  a_r1_one_restart_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_next, restart_zero}));

  // R2: a stop request from a running core removes the clock enable
  a_r2_stop_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && halt_set) |=> !core_clk_en);

  // R4, R6, R7: the enable only returns together with an indication
  a_r7_enable_with_reason: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> (resume_next || restart_zero));

  // R8: on resume the prescaler is all ones and the counter all ones or one less
  a_r8_pair_on_resume: assert property (@(posedge clk) disable iff (!rst_n)
    resume_next |-> ((wdt_pre == '1) &&
                     ((wdt_cnt == '1) || (wdt_cnt == {{(CNT_W-1){1'b1}}, 1'b0}))));

  // R6: a resume pulse lasts one cycle
  a_r6_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume_next |=> !resume_next);
endmodule

bind halt_wake_ctrl halt_wake_ctrl_checker #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .halt_set     (halt_set),
  .core_clk_en  (core_clk_en),
  .resume_next  (resume_next),
  .restart_zero (restart_zero),
  .wdt_pre      (wdt_pre),
  .wdt_cnt      (wdt_cnt)
);

// File: tb/halt_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module halt_wake_ctrl_tb_top;
  localparam int TC_DIV = 10;
  localparam int DELAY  = 256 * TC_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_set = 1'b0;
  logic       restart_pin = 1'b0;
  logic       wake_req = 1'b0;
  logic [1:0] clk_opt = 2'b00;
  logic       core_clk_en, resume_next, restart_zero, g7_level;
  logic [7:0] wdt_pre, wdt_cnt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  halt_wake_ctrl #(.TC_DIV(TC_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_set(halt_set), .restart_pin(restart_pin),
    .wake_req(wake_req), .clk_opt(clk_opt), .core_clk_en(core_clk_en),
    .resume_next(resume_next), .restart_zero(restart_zero), .g7_level(g7_level),
    .wdt_pre(wdt_pre), .wdt_cnt(wdt_cnt)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_stop();
    halt_set = 1'b1;
    nclk(1);
    halt_set = 1'b0;
    chk("R2 enable low after stop", core_clk_en, 0);
    nclk(3);
    chk("R2 enable stays low", core_clk_en, 0);
  endtask

  task automatic crystal_run(input string tag);
    int n;
    wake_req = 1'b1;
    nclk(1);
    wake_req = 1'b0;
    chk({tag, " R7 no immediate exit"}, core_clk_en, 0);
    n = 0;
    while (!core_clk_en && n < 5000) begin
      nclk(1);
      n = n + 1;
      if (n == 100) wake_req = 1'b1;
      if (n == 101) wake_req = 1'b0;
      if (n == 200) restart_pin = 1'b1;
      if (n == 300) restart_pin = 1'b0;
    end
    chk({tag, " R7 R10 delay length"}, n, DELAY);
    chk({tag, " R7 resume pulse"}, resume_next, 1);
    chk({tag, " R8 prescaler wrapped"}, wdt_pre, 255);
    chk({tag, " R8 counter stepped"}, wdt_cnt, 254);
    nclk(1);
    chk({tag, " R7 resume single"}, resume_next, 0);
  endtask

  initial begin
    nclk(3);
    chk("R1 enable in reset", core_clk_en, 0);
    chk("R1 restart in reset", restart_zero, 0);
    rst_n = 1'b1;
    nclk(1);
    chk("R1 enable after release", core_clk_en, 1);
    chk("R1 restart pulse", restart_zero, 1);
    chk("R1 prescaler cleared", wdt_pre, 0);
    chk("R1 counter cleared", wdt_cnt, 0);
    nclk(1);
    chk("R1 restart single", restart_zero, 0);

    wake_req = 1'b1;
    nclk(2);
    wake_req = 1'b0;
    chk("R6 wake while running ignored", resume_next, 0);
    chk("R6 running enable kept", core_clk_en, 1);

    for (int opt = 1; opt < 4; opt++) begin
      for (int src = 0; src < 2; src++) begin
        clk_opt = opt[1:0];
        enter_stop();
        halt_set = 1'b1;
        nclk(2);
        halt_set = 1'b0;
        nclk(1);
        chk("R3 stop strobe while stopped", core_clk_en, 0);
        if (src == 0) begin
          wake_req = 1'b1;
          nclk(1);
          wake_req = 1'b0;
          chk("R6 R12 wake exit enable", core_clk_en, 1);
          chk("R6 R12 wake resume", resume_next, 1);
          chk("R8 R12 prescaler loaded", wdt_pre, 255);
          chk("R8 R12 counter loaded", wdt_cnt, 255);
          nclk(1);
          chk("R6 resume single", resume_next, 0);
        end else begin
          restart_pin = 1'b1;
          nclk(1);
          chk("R11 level after one edge", g7_level, 0);
          nclk(1);
          chk("R11 level after two edges", g7_level, 1);
          chk("R4 not yet", core_clk_en, 0);
          nclk(1);
          chk("R4 R12 pin exit enable", core_clk_en, 1);
          chk("R4 R12 pin resume", resume_next, 1);
          chk("R8 pin prescaler loaded", wdt_pre, 255);
          restart_pin = 1'b0;
          nclk(3);
          chk("R11 level low again", g7_level, 0);
        end
      end
    end

    clk_opt = 2'b00;
    enter_stop();
    restart_pin = 1'b1;
    nclk(6);
    chk("R5 pin ignored with crystal", core_clk_en, 0);
    chk("R5 no resume", resume_next, 0);
    restart_pin = 1'b0;
    nclk(3);
    crystal_run("first");

    nclk(7);
    enter_stop();
    crystal_run("R13 second");

    enter_stop();
    rst_n = 1'b0;
    nclk(2);
    chk("R9 enable held in reset", core_clk_en, 0);
    rst_n = 1'b1;
    nclk(1);
    chk("R9 reset exit enable", core_clk_en, 1);
    chk("R9 reset exit restart", restart_zero, 1);
    chk("R9 reset exit no resume", resume_next, 0);

    nclk(2);
    enter_stop();
    wake_req = 1'b1;
    nclk(1);
    wake_req = 1'b0;
    nclk(50);
    chk("R9 still warming", core_clk_en, 0);
    rst_n = 1'b0;
    nclk(1);
    rst_n = 1'b1;
    nclk(1);
    chk("R9 reset cuts delay enable", core_clk_en, 1);
    chk("R9 reset cuts delay restart", restart_zero, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule